// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Command and Status Registers

This block is a serial transceiver for start/stop framed characters. It sits on a small processor bus with a one-bit register select. Software writes characters to a transmit holding buffer and reads received characters from a receive buffer. A write-only command register turns the transmitter and receiver on, drives two active-low modem-control outputs, forces a break on the line, clears the error flags and resets the block internally. A read-only status register shows buffer readiness, three receive error flags and the state of a modem input.

The bit rate comes from a fixed divisor of the system clock. The divisor produces a tick at sixteen times the bit rate. The receiver uses that tick to find the middle of each bit, and it checks the start bit half a bit after the falling edge. This rejects short low glitches.

Top module: `uart_cmdstat`

## Requirements
- R1: Register select `bus_addr`=0 reaches the data buffers and `bus_addr`=1 reaches the command register (write) or the status register (read). After reset the status reads 0x05 (with `dsr_n_in` high), `ser_tx` is high, and `dtr_n_out` and `rts_n_out` are high.
- R2: The command bits are: bit 0 transmit enable, bit 1 terminal-ready, bit 2 receive enable, bit 3 break, bit 4 error clear, bit 5 request-to-send, bit 6 internal reset. Bit 7 is ignored.
- R3: Command bit 1 set drives `dtr_n_out` low, and command bit 5 set drives `rts_n_out` low, from the cycle after the write. Clearing either bit drives its output high again.
- R4: While command bit 3 is set, `ser_tx` stays low on every cycle.
- R5: A frame is sent as follows: a start bit of 0, then DATA_BITS data bits least significant bit first, then an even parity bit when PARITY_EN is set (the data bits and parity together hold an even number of ones), then one stop bit of 1. Every bit lasts 16 ticks, and one tick occurs every CLK_PER_TICK clocks. The line idles high.
- R6: A character written to the data register waits in the holding buffer until transmit enable is set. Status bit 0 (transmit ready) is 1 when the holding buffer is empty. Status bit 2 (transmitter empty) is 1 when the holding buffer is empty and no frame is being sent. A data write while the holding buffer is full is ignored.
- R7: With receive enable set, a received frame sets status bit 1 (receive ready). A data read returns the character and clears bit 1. A low pulse shorter than half a bit starts no character. With receive enable clear, no character is received.
- R8: A received parity bit that breaks even parity sets status bit 3. The character is still delivered.
- R9: A stop bit sampled low sets status bit 5. The receiver then waits for the line to go high before it looks for the next start bit.
- R10: A character that completes while receive ready is still set sets status bit 4 (overrun). The buffer then holds the newer character.
- R11: A command write with bit 4 set clears status bits 3, 4 and 5. Bit 4 is not kept, and the other bits of that write take effect.
- R12: A command write with bit 6 set clears every command bit, empties both buffers, clears the error flags and stops both serial engines. The other bits of that write are ignored.
- R13: Status bit 7 is the inverse of `dsr_n_in`, taken through a two-stage synchronizer. Status bit 6 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access qualifier |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 1 | Register select: 0 data, 1 command/status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from select) |
| ser_tx | output | 1 | Serial transmit line |
| ser_rx | input | 1 | Serial receive line |
| dsr_n_in | input | 1 | Active-low modem input, reported in status |
| dtr_n_out | output | 1 | Active-low terminal-ready output |
| rts_n_out | output | 1 | Active-low request-to-send output |

## Verification
The properties assume that a bus access is a single-cycle strobe with `bus_sel` set. They also assume that read and write are never asserted together, so one access is decoded per cycle. The bench drives every access on a falling clock edge and releases it one cycle later. The serial input is driven only with whole bit periods of 32 clocks, except for the deliberately short glitch, so the receiver's sampling point always falls well inside a bit. The bench sends a character only after the previous frame has finished, and it never pulses the break and internal-reset bits while it is measuring a frame.

// File: rtl/uart_cs_pkg.sv
package uart_cs_pkg;

    localparam int CMD_TXEN  = 0;
    localparam int CMD_DTR   = 1;
    localparam int CMD_RXEN  = 2;
    localparam int CMD_BRK   = 3;
    localparam int CMD_ECLR  = 4;
    localparam int CMD_RTS   = 5;
    localparam int CMD_IRST  = 6;

    localparam int ST_TXRDY  = 0;
    localparam int ST_RXRDY  = 1;
    localparam int ST_TXMT   = 2;
    localparam int ST_PERR   = 3;
    localparam int ST_OERR   = 4;
    localparam int ST_FERR   = 5;
    localparam int ST_SYNC   = 6;
    localparam int ST_DSR    = 7;

    localparam int OVERSAMPLE = 16;

    typedef struct packed {
        logic txen;
        logic dtr;
        logic rxen;
        logic brk;
        logic rts;
    } cmd_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_WAIT
    } rx_state_e;

endpackage

// File: rtl/uart_cs_tick.sv
module uart_cs_tick #(
    parameter int CLK_PER_TICK = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (CLK_PER_TICK <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(CLK_PER_TICK);
            localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/uart_cs_tx.sv
module uart_cs_tx #(
    parameter int DATA_BITS = 8,
    parameter int PARITY_EN = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 tick,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] data,
    output logic                 busy,
    output logic                 line
);
    import uart_cs_pkg::*;

    localparam int FRAME = DATA_BITS + 2 + ((PARITY_EN != 0) ? 1 : 0);
    localparam int BW    = $clog2(FRAME + 1);

    typedef struct packed {
        logic             busy;
        logic [FRAME-1:0] shift;
        logic [3:0]       tcnt;
        logic [BW-1:0]    bleft;
    } tx_t;

    tx_t q, d;
    logic [FRAME-1:0] frame;

    always_comb begin
        frame = '1;
        frame[0] = 1'b0;
        frame[DATA_BITS:1] = data;
        if (PARITY_EN != 0) frame[DATA_BITS+1] = ^data;
    end

    always_comb begin
        d = q;
        if (flush) begin
            d.busy  = 1'b0;
            d.shift = '1;
            d.tcnt  = '0;
            d.bleft = '0;
        end else if (load && !q.busy) begin
            d.busy  = 1'b1;
            d.shift = frame;
            d.tcnt  = '0;
            d.bleft = BW'(FRAME);
        end else if (q.busy && tick) begin
            if (q.tcnt == 4'(OVERSAMPLE - 1)) begin
                d.tcnt  = '0;
                d.shift = {1'b1, q.shift[FRAME-1:1]};
                d.bleft = q.bleft - 1'b1;
                if (q.bleft == BW'(1)) d.busy = 1'b0;
            end else begin
                d.tcnt = q.tcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.busy  <= 1'b0;
            q.shift <= '1;
            q.tcnt  <= '0;
            q.bleft <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy = q.busy;
    assign line = q.busy ? q.shift[0] : 1'b1;
endmodule

// File: rtl/uart_cs_rx.sv
module uart_cs_rx #(
    parameter int DATA_BITS = 8,
    parameter int PARITY_EN = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 tick,
    input  logic                 enable,
    input  logic                 rx_in,
    output logic                 char_valid,
    output logic [DATA_BITS-1:0] char_data,
    output logic                 char_perr,
    output logic                 char_ferr
);
    import uart_cs_pkg::*;

    localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [3:0] MID  = 4'(OVERSAMPLE / 2 - 1);
    localparam logic [3:0] LAST = 4'(OVERSAMPLE - 1);

    typedef struct packed {
        logic [1:0]           sync;
        rx_state_e            state;
        logic [3:0]           tcnt;
        logic [BW-1:0]        bidx;
        logic [DATA_BITS-1:0] shreg;
        logic                 par_bad;
        logic                 valid;
        logic [DATA_BITS-1:0] data;
        logic                 perr;
        logic                 ferr;
    } rx_t;

    rx_t q, d;
    logic rx_s;

    assign rx_s = q.sync[1];

    always_comb begin
        d = q;
        d.sync  = {q.sync[0], rx_in};
        d.valid = 1'b0;
        if (flush) begin
            d.state = RX_IDLE;
            d.tcnt  = '0;
        end else begin
            case (q.state)
                RX_IDLE: begin
                    if (tick && enable && !rx_s) begin
                        d.state   = RX_START;
                        d.tcnt    = '0;
                        d.par_bad = 1'b0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (q.tcnt == MID) begin
                            d.tcnt  = '0;
                            d.bidx  = '0;
                            d.state = rx_s ? RX_IDLE : RX_DATA;
                        end else begin
                            d.tcnt = q.tcnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (q.tcnt == LAST) begin
                            d.tcnt  = '0;
                            d.shreg = {rx_s, q.shreg[DATA_BITS-1:1]};
                            if (q.bidx == BW'(DATA_BITS - 1))
                                d.state = (PARITY_EN != 0) ? RX_PAR : RX_STOP;
                            else
                                d.bidx = q.bidx + 1'b1;
                        end else begin
                            d.tcnt = q.tcnt + 1'b1;
                        end
                    end
                end
                RX_PAR: begin
                    if (tick) begin
                        if (q.tcnt == LAST) begin
                            d.tcnt    = '0;
                            d.par_bad = rx_s ^ (^q.shreg);
                            d.state   = RX_STOP;
                        end else begin
                            d.tcnt = q.tcnt + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (q.tcnt == LAST) begin
                            d.tcnt  = '0;
                            d.valid = 1'b1;
                            d.data  = q.shreg;
                            d.perr  = q.par_bad;
                            d.ferr  = !rx_s;
                            d.state = rx_s ? RX_IDLE : RX_WAIT;
                        end else begin
                            d.tcnt = q.tcnt + 1'b1;
                        end
                    end
                end
                RX_WAIT: begin
                    if (rx_s) d.state = RX_IDLE;
                end
                default: d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync    <= 2'b11;
            q.state   <= RX_IDLE;
            q.tcnt    <= '0;
            q.bidx    <= '0;
            q.shreg   <= '0;
            q.par_bad <= 1'b0;
            q.valid   <= 1'b0;
            q.data    <= '0;
            q.perr    <= 1'b0;
            q.ferr    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign char_valid = q.valid;
    assign char_data  = q.data;
    assign char_perr  = q.perr;
    assign char_ferr  = q.ferr;
endmodule

// File: rtl/uart_cmdstat.sv
module uart_cmdstat #(
    parameter int DATA_BITS    = 8,
    parameter int PARITY_EN    = 1,
    parameter int CLK_PER_TICK = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       ser_tx,
    input  logic       ser_rx,
    input  logic       dsr_n_in,
    output logic       dtr_n_out,
    output logic       rts_n_out
);
    import uart_cs_pkg::*;

    localparam int BUS_W = 8;

    typedef struct packed {
        cmd_t                 cmd;
        logic [DATA_BITS-1:0] hold;
        logic                 hold_full;
        logic [DATA_BITS-1:0] rxbuf;
        logic                 rx_full;
        logic                 perr;
        logic                 oerr;
        logic                 ferr;
        logic [1:0]           dsr_sync;
    } top_t;

    top_t q, d;

    logic                 tick;
    logic                 wr_data, wr_cmd, rd_data;
    logic                 irst;
    logic                 tx_load, tx_busy, tx_line;
    logic                 char_valid, char_perr, char_ferr;
    logic [DATA_BITS-1:0] char_data;
    logic [BUS_W-1:0]     status;

    // Signals shared with the bound checker
    logic                 rx_full_w, hold_full_w, brk_w;
    logic [2:0]           err_w;

    assign wr_data = bus_sel && bus_wr && !bus_addr;
    assign wr_cmd  = bus_sel && bus_wr &&  bus_addr;
    assign rd_data = bus_sel && bus_rd && !bus_addr;
    assign irst    = wr_cmd && bus_wdata[CMD_IRST];
    assign tx_load = tick && !tx_busy && q.hold_full && q.cmd.txen;

    uart_cs_tick #(.CLK_PER_TICK(CLK_PER_TICK)) i_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    uart_cs_tx #(.DATA_BITS(DATA_BITS), .PARITY_EN(PARITY_EN)) i_tx (
        .clk  (clk),
        .rst_n(rst_n),
        .flush(irst),
        .tick (tick),
        .load (tx_load),
        .data (q.hold),
        .busy (tx_busy),
        .line (tx_line)
    );

    uart_cs_rx #(.DATA_BITS(DATA_BITS), .PARITY_EN(PARITY_EN)) i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (irst),
        .tick      (tick),
        .enable    (q.cmd.rxen),
        .rx_in     (ser_rx),
        .char_valid(char_valid),
        .char_data (char_data),
        .char_perr (char_perr),
        .char_ferr (char_ferr)
    );

    always_comb begin
        d = q;
        d.dsr_sync = {q.dsr_sync[0], ~dsr_n_in};

        // transmit holding buffer
        if (tx_load) d.hold_full = 1'b0;
        if (wr_data && !q.hold_full) begin
            d.hold      = bus_wdata[DATA_BITS-1:0];
            d.hold_full = 1'b1;
        end

        // receive buffer and error flags
        if (rd_data) d.rx_full = 1'b0;
        if (char_valid) begin
            if (q.rx_full && !rd_data) d.oerr = 1'b1;
            d.rxbuf   = char_data;
            d.rx_full = 1'b1;
            if (char_perr) d.perr = 1'b1;
            if (char_ferr) d.ferr = 1'b1;
        end

        // command register
        if (irst) begin
            d.cmd       = '0;
            d.hold_full = 1'b0;
            d.rx_full   = 1'b0;
            d.perr      = 1'b0;
            d.oerr      = 1'b0;
            d.ferr      = 1'b0;
        end else if (wr_cmd) begin
            d.cmd.txen = bus_wdata[CMD_TXEN];
            d.cmd.dtr  = bus_wdata[CMD_DTR];
            d.cmd.rxen = bus_wdata[CMD_RXEN];
            d.cmd.brk  = bus_wdata[CMD_BRK];
            d.cmd.rts  = bus_wdata[CMD_RTS];
            if (bus_wdata[CMD_ECLR]) begin
                d.perr = 1'b0;
                d.oerr = 1'b0;
                d.ferr = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cmd       <= '0;
            q.hold      <= '0;
            q.hold_full <= 1'b0;
            q.rxbuf     <= '0;
            q.rx_full   <= 1'b0;
            q.perr      <= 1'b0;
            q.oerr      <= 1'b0;
            q.ferr      <= 1'b0;
            q.dsr_sync  <= 2'b00;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        status           = '0;
        status[ST_TXRDY] = !q.hold_full;
        status[ST_RXRDY] = q.rx_full;
        status[ST_TXMT]  = !q.hold_full && !tx_busy;
        status[ST_PERR]  = q.perr;
        status[ST_OERR]  = q.oerr;
        status[ST_FERR]  = q.ferr;
        status[ST_SYNC]  = 1'b0;
        status[ST_DSR]   = q.dsr_sync[1];
    end

    assign bus_rdata   = bus_addr ? status : BUS_W'(q.rxbuf);
    assign ser_tx      = q.cmd.brk ? 1'b0 : tx_line;
    assign dtr_n_out   = ~q.cmd.dtr;
    assign rts_n_out   = ~q.cmd.rts;

    assign rx_full_w   = q.rx_full;
    assign hold_full_w = q.hold_full;
    assign brk_w       = q.cmd.brk;
    assign err_w       = {q.ferr, q.oerr, q.perr};
endmodule

// File: rtl/uart_cs_checker.sv
module uart_cs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       bus_addr,
    input logic [7:0] bus_wdata,
    input logic       ser_tx,
    input logic       dtr_n_out,
    input logic       rts_n_out,
    input logic       tx_busy,
    input logic       char_valid,
    input logic       rx_full_w,
    input logic       hold_full_w,
    input logic       brk_w,
    input logic [2:0] err_w
);
    logic cw, dr;
    assign cw = bus_sel && bus_wr && bus_addr;
    assign dr = bus_sel && bus_rd && !bus_addr;

    p_brk_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && bus_wdata[3] && !bus_wdata[6]) |=> !ser_tx);

    p_brk_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_w && !cw) |=> !ser_tx);

    p_dtr_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && bus_wdata[1] && !bus_wdata[6]) |=> !dtr_n_out);

    p_rts_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && bus_wdata[5] && !bus_wdata[6]) |=> !rts_n_out);

    p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !brk_w) |-> ser_tx);

    p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dr && !char_valid) |=> !rx_full_w);

    p_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && rx_full_w && !dr && !cw) |=> err_w[1]);

    p_err_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && bus_wdata[4]) |=> (err_w == 3'b000));

    p_int_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && bus_wdata[6]) |=>
            (dtr_n_out && rts_n_out && ser_tx && !rx_full_w && !hold_full_w));
endmodule

bind uart_cmdstat uart_cs_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .ser_tx     (ser_tx),
    .dtr_n_out  (dtr_n_out),
    .rts_n_out  (rts_n_out),
    .tx_busy    (tx_busy),
    .char_valid (char_valid),
    .rx_full_w  (rx_full_w),
    .hold_full_w(hold_full_w),
    .brk_w      (brk_w),
    .err_w      (err_w)
);

// File: tb/test_uart_cmdstat.sv
`timescale 1ns/1ps
module test_uart_cmdstat;
    localparam int BIT_CLK = 32;   // 16 ticks x 2 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ser_tx, dtr_n_out, rts_n_out;
    logic       ser_rx = 1'b1;
    logic       dsr_n_in = 1'b1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_cmdstat i_uart_cmdstat (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ser_tx(ser_tx), .ser_rx(ser_rx),
        .dsr_n_in(dsr_n_in), .dtr_n_out(dtr_n_out), .rts_n_out(rts_n_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic a, input logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic rx_frame(input logic [7:0] v, input bit bad_par, input bit bad_stop);
        @(negedge clk);
        ser_rx = 1'b0; wait_clk(BIT_CLK);
        for (int i = 0; i < 8; i++) begin ser_rx = v[i]; wait_clk(BIT_CLK); end
        ser_rx = (^v) ^ bad_par; wait_clk(BIT_CLK);
        ser_rx = !bad_stop; wait_clk(BIT_CLK);
        ser_rx = 1'b1; wait_clk(40);
    endtask

    task automatic tx_capture(input string tag, input logic [7:0] exp);
        int n = 0;
        logic st, p, sp;
        logic [7:0] v;
        while (ser_tx !== 1'b0 && n < 2000) begin @(negedge clk); n++; end
        wait_clk(BIT_CLK / 2); st = ser_tx;
        for (int i = 0; i < 8; i++) begin wait_clk(BIT_CLK); v[i] = ser_tx; end
        wait_clk(BIT_CLK); p = ser_tx;
        wait_clk(BIT_CLK); sp = ser_tx;
        chk({tag, " R5 start bit"}, st, 1'b0);
        chk({tag, " R5 data"}, v, exp);
        chk({tag, " R5 even parity"}, p, ^exp);
        chk({tag, " R5 stop bit"}, sp, 1'b1);
    endtask

    task automatic t_reset;
        logic [7:0] s;
        bus_read(1'b1, s);
        chk("R1 reset status", s, 8'h05);
        chk("R1 reset ser_tx", ser_tx, 1'b1);
        chk("R1 reset dtr_n", dtr_n_out, 1'b1);
        chk("R1 reset rts_n", rts_n_out, 1'b1);
    endtask

    task automatic t_modem;
        bus_write(1'b1, 8'h22);
        wait_clk(1);
        chk("R3 dtr low", dtr_n_out, 1'b0);
        chk("R3 rts low", rts_n_out, 1'b0);
        bus_write(1'b1, 8'h02);
        chk("R2 rts bit5 cleared", rts_n_out, 1'b1);
        chk("R2 dtr bit1 kept", dtr_n_out, 1'b0);
        bus_write(1'b1, 8'h00);
        chk("R3 dtr high", dtr_n_out, 1'b1);
    endtask

    task automatic t_tx;
        logic [7:0] s;
        bit low_seen = 1'b0;
        bus_write(1'b0, 8'h5A);
        for (int i = 0; i < 200; i++) begin @(negedge clk); if (!ser_tx) low_seen = 1'b1; end
        chk("R6 no send while disabled", low_seen, 1'b0);
        bus_read(1'b1, s);
        chk("R6 holding full status", s, 8'h00);
        bus_write(1'b0, 8'h11);                 // ignored: holding full
        bus_write(1'b1, 8'h01);
        tx_capture("tx 5A", 8'h5A);
        low_seen = 1'b0;
        for (int i = 0; i < 500; i++) begin @(negedge clk); if (!ser_tx) low_seen = 1'b1; end
        chk("R6 overwrite ignored, no second frame", low_seen, 1'b0);
        bus_read(1'b1, s);
        chk("R6 transmitter empty", s, 8'h05);
        bus_write(1'b0, 8'h80);
        tx_capture("tx 80", 8'h80);
        bus_write(1'b0, 8'hFF);
        tx_capture("tx FF", 8'hFF);
    endtask

    task automatic t_break;
        bit high_seen = 1'b0;
        wait_clk(60);
        bus_write(1'b1, 8'h09);
        for (int i = 0; i < 300; i++) begin @(negedge clk); if (ser_tx) high_seen = 1'b1; end
        chk("R4 break holds line low", high_seen, 1'b0);
        bus_write(1'b1, 8'h01);
        wait_clk(1);
        chk("R4 break released", ser_tx, 1'b1);
    endtask

    task automatic t_rx;
        logic [7:0] s, v;
        bus_write(1'b1, 8'h00);
        rx_frame(8'h3C, 1'b0, 1'b0);
        bus_read(1'b1, s);
        chk("R7 receiver disabled", s, 8'h05);
        bus_write(1'b1, 8'h04);
        rx_frame(8'hA5, 1'b0, 1'b0);
        bus_read(1'b1, s);
        chk("R7 receive ready", s, 8'h07);
        bus_read(1'b0, v);
        chk("R7 data", v, 8'hA5);
        bus_read(1'b1, s);
        chk("R7 ready cleared by read", s, 8'h05);
        @(negedge clk); ser_rx = 1'b0; wait_clk(6); ser_rx = 1'b1; wait_clk(500);
        bus_read(1'b1, s);
        chk("R7 glitch rejected", s, 8'h05);
    endtask

    task automatic t_errors;
        logic [7:0] s, v;
        rx_frame(8'h6B, 1'b1, 1'b0);
        bus_read(1'b1, s);
        chk("R8 parity error", s, 8'h0F);
        bus_read(1'b0, v);
        chk("R8 data still delivered", v, 8'h6B);
        bus_write(1'b1, 8'h14);
        bus_read(1'b1, s);
        chk("R11 errors cleared", s, 8'h05);
        rx_frame(8'h01, 1'b0, 1'b0);
        bus_read(1'b1, s);
        chk("R11 error bit not kept, rx still on", s, 8'h07);
        bus_read(1'b0, v);
        rx_frame(8'hC3, 1'b0, 1'b1);
        bus_read(1'b1, s);
        chk("R9 framing error", s, 8'h27);
        bus_read(1'b0, v);
        rx_frame(8'h42, 1'b0, 1'b0);
        bus_read(1'b0, v);
        chk("R9 recovers after bad stop", v, 8'h42);
        bus_write(1'b1, 8'h14);
        rx_frame(8'h10, 1'b0, 1'b0);
        rx_frame(8'h20, 1'b0, 1'b0);
        bus_read(1'b1, s);
        chk("R10 overrun", s, 8'h17);
        bus_read(1'b0, v);
        chk("R10 newer char kept", v, 8'h20);
        bus_write(1'b1, 8'h14);
    endtask

    task automatic t_ireset;
        logic [7:0] s;
        bus_write(1'b1, 8'h26);
        rx_frame(8'h55, 1'b0, 1'b0);
        bus_write(1'b0, 8'h33);
        bus_read(1'b1, s);
        chk("R12 before reset", s, 8'h02);
        bus_write(1'b1, 8'h63);
        bus_read(1'b1, s);
        chk("R12 buffers emptied", s, 8'h05);
        chk("R12 dtr released", dtr_n_out, 1'b1);
        chk("R12 rts released", rts_n_out, 1'b1);
        rx_frame(8'h77, 1'b0, 1'b0);
        bus_read(1'b1, s);
        chk("R12 receive enable cleared", s, 8'h05);
    endtask

    task automatic t_dsr;
        logic [7:0] s;
        dsr_n_in = 1'b0;
        wait_clk(4);
        bus_read(1'b1, s);
        chk("R13 dsr active, sync bit zero", s, 8'h85);
        dsr_n_in = 1'b1;
        wait_clk(4);
        bus_read(1'b1, s);
        chk("R13 dsr inactive", s, 8'h05);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_modem();
        t_tx();
        t_break();
        t_rx();
        t_errors();
        t_ireset();
        t_dsr();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule